// File: doc/BRIEF.md
# DRAM Open-Row Command Sequencer

This block takes single read or write requests with a flat 25-bit address and turns them into command-pin activity for one rank of DDR2-style memory with four banks. Each address is split into a bank, a row and a column. When no row is open, the block first opens the row with an activate command. It then issues a column read or write to that row. The row stays open, so a stream of requests to the same row shares one activate and one precharge, and only the column command is repeated for each burst of eight words.

A request to a different bank or row closes the open row with a precharge and then activates the new one. When the requester stops presenting requests, the open row is closed as soon as the column-to-precharge delay has elapsed. Four parameterized gap counters set the minimum spacing between commands: activate to column, column to column, column to precharge, and precharge to activate. The requester sees a single ready signal. While ready is low, the block is either holding an accepted request or waiting out a spacing gap.

Top module: `dram_row_seq`

## Requirements
- R1: The request address is split as bank = addr[24:23], row = addr[22:10] and column = addr[9:0], giving four banks of 8192 rows by 1024 columns.
- R2: Command pins are active low and registered, and cs_n is held at 0 at all times. The {ras_n,cas_n,we_n} codes are: idle 111, activate 011, read 101, write 100, precharge 010. The idle code is driven in every cycle that carries no command.
- R3: A request accepted while no row is open produces an activate in the cycle after the accepting clock edge, with the bank pins carrying the request bank and the address pins carrying the request row.
- R4: A request that hits the open bank and row produces only a read (write when req_write is 1) column command, with no new activate. The bank pins carry the bank, address[9:0] carries the column, and address[12:10] is 0.
- R5: A request whose bank or row differs from the open row causes a precharge of the open row first: the bank pins carry the open bank and the address pins are all 0. An activate of the new row and then its column command follow.
- R6: When a row is open, no request is valid, and the column-to-precharge delay has elapsed, a precharge closes the row. If a hitting request is presented in that same cycle, it gets its column command and no precharge is issued.
- R7: req_ready is high after reset. It is low while a command-spacing gap runs and while an accepted request still waits for its column command.
- R8: For back-to-back traffic, commands are spaced exactly as follows: T_RCD cycles from activate to column, T_CCD from column to column, T_CP from column to precharge, and T_RP from precharge to activate (defaults 3, 4, 6 and 3).
- R9: At most one row is open at a time. No activate is issued while a row is open, and no column command is issued while none is open.
- R10: After reset, with no request presented, the pins show the idle code with bank and address 0, and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are updated on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Flat address {bank,row,column} |
| req_ready | output | 1 | Request accepted on an edge where valid and ready are both 1 |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank pins |
| cmd_addr | output | 13 | Address pins |

## Verification
Two functions can fall in the same cycle: the idle close of an open row becoming due, and a new request to that same row arriving. The bench provokes this by pausing after a column command. A pause that lands the next request exactly on the cycle the column-to-precharge delay expires must yield a column command spaced T_CP after the previous one, with no precharge. A pause one cycle longer must yield a precharge followed by a fresh activate. Both outcomes are judged from the logged command stream, including the kinds, the fields and the cycle gaps.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int PIN_W  = ROW_W;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } dram_loc_t;

  // flat address -> bank/row/column (bank in the top bits)
  function automatic dram_loc_t split_addr(input logic [ADDR_W-1:0] a);
    return dram_loc_t'(a);
  endfunction

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(input cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

  // column onto the address pins, upper bits (incl. auto-close bit) zero
  function automatic logic [PIN_W-1:0] col_to_pins(input logic [COL_W-1:0] c);
    return {{(PIN_W-COL_W){1'b0}}, c};
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dram_pin_driver.sv
module dram_pin_driver
  import dram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] ba_in,
  input  logic [PIN_W-1:0]  addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [PIN_W-1:0]  addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ras_n, cas_n, we_n} <= 3'b111;
      ba   <= '0;
      addr <= '0;
    end else begin
      {ras_n, cas_n, we_n} <= cmd_pins(cmd);
      ba   <= ba_in;
      addr <= addr_in;
    end
  end

  // single rank: always selected, idle code carries the no-command cycles
  assign cs_n = 1'b0;
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_CCD = 4,
  parameter int T_CP  = 6,
  parameter int T_RP  = 3,
  parameter int TW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              gap_busy,
  input  logic              pre_busy,
  output logic              gap_load,
  output logic [TW-1:0]     gap_val,
  output logic              pre_load,
  output cmd_e              nxt_cmd,
  output logic [BANK_W-1:0] nxt_ba,
  output logic [PIN_W-1:0]  nxt_addr,
  output logic              ev_act,
  output logic              ev_col,
  output logic              ev_pre,
  output logic              row_open
);
  logic              pend_v, pend_wr;
  dram_loc_t         pend_loc;
  logic [BANK_W-1:0] open_bank;
  logic [ROW_W-1:0]  open_row;

  logic      take, cur_v, cur_wr, hit;
  dram_loc_t cur_loc;

  assign req_ready = !pend_v && !gap_busy;
  assign take      = req_valid && req_ready;
  assign cur_v     = pend_v || take;
  assign cur_wr    = pend_v ? pend_wr  : req_write;
  assign cur_loc   = pend_v ? pend_loc : split_addr(req_addr);
  assign hit       = row_open && (cur_loc.bank == open_bank) && (cur_loc.row == open_row);

  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_ba   = '0;
    nxt_addr = '0;
    gap_load = 1'b0;
    gap_val  = '0;
    pre_load = 1'b0;
    if (!gap_busy) begin
      if (cur_v) begin
        if (hit) begin
          nxt_cmd  = cur_wr ? CMD_WR : CMD_RD;
          nxt_ba   = cur_loc.bank;
          nxt_addr = col_to_pins(cur_loc.col);
          gap_load = 1'b1;
          gap_val  = TW'(T_CCD - 1);
          pre_load = 1'b1;
        end else if (row_open) begin
          if (!pre_busy) begin
            nxt_cmd  = CMD_PRE;
            nxt_ba   = open_bank;
            gap_load = 1'b1;
            gap_val  = TW'(T_RP - 1);
          end
        end else begin
          nxt_cmd  = CMD_ACT;
          nxt_ba   = cur_loc.bank;
          nxt_addr = cur_loc.row;
          gap_load = 1'b1;
          gap_val  = TW'(T_RCD - 1);
        end
      end else if (row_open && !pre_busy) begin
        nxt_cmd  = CMD_PRE;
        nxt_ba   = open_bank;
        gap_load = 1'b1;
        gap_val  = TW'(T_RP - 1);
      end
    end
  end

  assign ev_act = (nxt_cmd == CMD_ACT);
  assign ev_pre = (nxt_cmd == CMD_PRE);
  assign ev_col = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_wr   <= 1'b0;
      pend_loc  <= '0;
      row_open  <= 1'b0;
      open_bank <= '0;
      open_row  <= '0;
    end else begin
      if (take && !ev_col) begin
        pend_v   <= 1'b1;
        pend_wr  <= req_write;
        pend_loc <= split_addr(req_addr);
      end else if (pend_v && ev_col) begin
        pend_v <= 1'b0;
      end
      if (ev_act) begin
        row_open  <= 1'b1;
        open_bank <= cur_loc.bank;
        open_row  <= cur_loc.row;
      end else if (ev_pre) begin
        row_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_CCD = 4,
  parameter int T_CP  = 6,
  parameter int T_RP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [PIN_W-1:0]  cmd_addr
);
  localparam int TMAX = max_of(max_of(T_RCD, T_CCD), max_of(T_CP, T_RP));
  localparam int TW   = $clog2(TMAX + 1);

  logic              gap_busy, pre_busy, gap_load, pre_load;
  logic [TW-1:0]     gap_val;
  cmd_e              nxt_cmd;
  logic [BANK_W-1:0] nxt_ba;
  logic [PIN_W-1:0]  nxt_addr;
  // named internal events, observed by the bound checker
  logic              ev_act, ev_col, ev_pre, row_open;

  dram_seq_ctrl #(
    .T_RCD(T_RCD), .T_CCD(T_CCD), .T_CP(T_CP), .T_RP(T_RP), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready),
    .gap_busy(gap_busy), .pre_busy(pre_busy),
    .gap_load(gap_load), .gap_val(gap_val), .pre_load(pre_load),
    .nxt_cmd(nxt_cmd), .nxt_ba(nxt_ba), .nxt_addr(nxt_addr),
    .ev_act(ev_act), .ev_col(ev_col), .ev_pre(ev_pre), .row_open(row_open)
  );

  dram_gap_timer #(.W(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .busy(gap_busy)
  );

  dram_gap_timer #(.W(TW)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(pre_load), .load_val(TW'(T_CP - 1)), .busy(pre_busy)
  );

  dram_pin_driver u_pins (
    .clk(clk), .rst_n(rst_n),
    .cmd(nxt_cmd), .ba_in(nxt_ba), .addr_in(nxt_addr),
    .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .ba(cmd_ba), .addr(cmd_addr)
  );
endmodule

// File: rtl/dram_row_seq_chk.sv
module dram_row_seq_chk #(
  parameter int T_RCD = 3,
  parameter int T_CCD = 4,
  parameter int T_CP  = 6,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic req_ready,
  input logic ev_act,
  input logic ev_col,
  input logic row_open
);
  localparam logic [7:0] L_RCD = 8'(T_RCD);
  localparam logic [7:0] L_CCD = 8'(T_CCD);
  localparam logic [7:0] L_CP  = 8'(T_CP);
  localparam logic [7:0] L_RP  = 8'(T_RP);

  logic act_seen, col_seen, pre_seen, pins_idle;
  assign act_seen  = ({ras_n, cas_n, we_n} == 3'b011);
  assign col_seen  = ({ras_n, cas_n} == 2'b10);
  assign pre_seen  = ({ras_n, cas_n, we_n} == 3'b010);
  assign pins_idle = ({ras_n, cas_n, we_n} == 3'b111);

  logic [7:0] since_act, since_col, since_pre;
  logic       pin_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_col <= 8'hFF;
      since_pre <= 8'hFF;
      pin_open  <= 1'b0;
    end else begin
      since_act <= act_seen ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
      since_col <= col_seen ? 8'd1 : ((since_col == 8'hFF) ? since_col : since_col + 8'd1);
      since_pre <= pre_seen ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
      if (act_seen)      pin_open <= 1'b1;
      else if (pre_seen) pin_open <= 1'b0;
    end
  end

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    pins_idle || act_seen || col_seen || pre_seen);

  a_r3_act_reaches_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> act_seen);

  a_r4_col_reaches_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col |=> col_seen);

  a_r7_ready_low_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_seen |-> !req_ready);

  a_r8_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    col_seen |-> (since_act >= L_RCD));

  a_r8_ccd: assert property (@(posedge clk) disable iff (!rst_n)
    col_seen |-> (since_col >= L_CCD));

  a_r8_cp: assert property (@(posedge clk) disable iff (!rst_n)
    pre_seen |-> (since_col >= L_CP));

  a_r8_rp: assert property (@(posedge clk) disable iff (!rst_n)
    act_seen |-> (since_pre >= L_RP));

  a_r9_no_double_open: assert property (@(posedge clk) disable iff (!rst_n)
    act_seen |-> !pin_open);

  a_r9_col_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
    col_seen |-> pin_open);

  a_r5_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_seen |-> !row_open);
endmodule

bind dram_row_seq dram_row_seq_chk #(
  .T_RCD(T_RCD), .T_CCD(T_CCD), .T_CP(T_CP), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
  .req_ready(req_ready), .ev_act(ev_act), .ev_col(ev_col), .row_open(row_open)
);

// File: tb/tb_dram_row_seq.sv
module tb_dram_row_seq;
  localparam int T_RCD = 3;
  localparam int T_CCD = 4;
  localparam int T_CP  = 6;
  localparam int T_RP  = 3;
  localparam int K_IDLE = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        pre;
    logic        act;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 2'd1, 13'h000C, 10'h000, 1'b0, 1'b1},
    '{1'b0, 2'd1, 13'h000C, 10'h008, 1'b0, 1'b0},
    '{1'b1, 2'd1, 13'h000C, 10'h010, 1'b0, 1'b0},
    '{1'b1, 2'd2, 13'h0055, 10'h3F8, 1'b1, 1'b1},
    '{1'b0, 2'd2, 13'h1FFF, 10'h000, 1'b1, 1'b1},
    '{1'b1, 2'd2, 13'h1FFF, 10'h008, 1'b0, 1'b0},
    '{1'b0, 2'd0, 13'h0000, 10'h000, 1'b1, 1'b1},
    '{1'b1, 2'd3, 13'h1FFF, 10'h3F8, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic        req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr;

  always #10 clk = ~clk;

  dram_row_seq #(.T_RCD(T_RCD), .T_CCD(T_CCD), .T_CP(T_CP), .T_RP(T_RP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .cmd_cs_n(cmd_cs_n),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
  );

  int checks = 0, errors = 0, cyc = 0, cs_bad = 0;
  int lk[64], lb[64], la[64], lc[64];
  int ln = 0;
  int ek[64], eb[64], ea[64], eg[64];
  string et[64];
  int en = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int kind_of(input logic r, input logic c, input logic w);
    case ({r, c, w})
      3'b111: return K_IDLE;
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return K_PRE;
      default: return 9;
    endcase
  endfunction

  function automatic int gap_for(input int a, input int b);
    if (b == K_PRE) return T_CP;
    if (b == K_ACT) return T_RP;
    if (a == K_ACT) return T_RCD;
    return T_CCD;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_cs_n !== 1'b0) cs_bad++;
      if (kind_of(cmd_ras_n, cmd_cas_n, cmd_we_n) != K_IDLE && ln < 64) begin
        lk[ln] = kind_of(cmd_ras_n, cmd_cas_n, cmd_we_n);
        lb[ln] = int'(cmd_ba);
        la[ln] = int'(cmd_addr);
        lc[ln] = cyc;
        ln++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int b, input int a, input int g, input string t);
    ek[en] = k; eb[en] = b; ea[en] = a; eg[en] = g; et[en] = t;
    en++;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic wr, input logic [1:0] b, input logic [12:0] r,
                      input logic [9:0] c, output int acc);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {b, r, c};   // R1 field placement
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc = cyc;
    @(negedge clk);
    check(req_ready == 1'b0, "R7 ready low after accept", int'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  task automatic compare_log(input string name);
    bit open = 1'b0;
    check(ln == en, {name, " R2 command count"}, ln, en);
    for (int j = 0; j < en && j < ln; j++) begin
      check(lk[j] == ek[j], {name, " R2 kind"}, lk[j], ek[j]);
      check(lb[j] == eb[j], {name, " ", et[j], " bank"}, lb[j], eb[j]);
      check(la[j] == ea[j], {name, " ", et[j], " address"}, la[j], ea[j]);
      if (j > 0 && eg[j] >= 0)
        check(lc[j] - lc[j-1] == eg[j], {name, " R8 spacing"}, lc[j] - lc[j-1], eg[j]);
      if (lk[j] == K_ACT) begin
        check(!open, {name, " R9 activate while open"}, int'(open), 0);
        open = 1'b1;
      end else if (lk[j] == K_PRE) begin
        open = 1'b0;
      end
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    report();
    $finish;
  end

  initial begin
    int acc, acc0, pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    check(cmd_cs_n == 1'b0, "R2 cs_n after reset", int'(cmd_cs_n), 0);
    check({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b111, "R10 idle code",
          int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), 7);
    check(cmd_ba == 2'd0, "R10 bank zero", int'(cmd_ba), 0);
    check(cmd_addr == 13'd0, "R10 address zero", int'(cmd_addr), 0);
    repeat (10) @(negedge clk);
    check(ln == 0, "R10 no command without request", ln, 0);

    // stream from the vector table, back to back
    ln = 0; en = 0; pb = 0;
    for (int i = 0; i < 8; i++) begin
      send(VEC[i].wr, VEC[i].bank, VEC[i].row, VEC[i].col, acc);
      if (i == 0) acc0 = acc;
    end
    repeat (30) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].pre) push(K_PRE, pb, 0, T_CP, "R5");
      if (VEC[i].act) push(K_ACT, int'(VEC[i].bank), int'(VEC[i].row), (i == 0) ? -1 : T_RP, "R1 R3");
      push(VEC[i].wr ? K_WR : K_RD, int'(VEC[i].bank), int'(VEC[i].col),
           (VEC[i].act ? T_RCD : T_CCD), "R1 R4");
      pb = int'(VEC[i].bank);
    end
    push(K_PRE, pb, 0, T_CP, "R6");
    compare_log("stream");
    check(ln > 0 && lc[0] == acc0 + 1, "R3 activate latency", (ln > 0) ? lc[0] - acc0 : -1, 1);

    // R6 boundary: request arriving exactly when the idle close falls due
    ln = 0; en = 0;
    send(1'b0, 2'd3, 13'h00AA, 10'h000, acc);
    send(1'b0, 2'd3, 13'h00AA, 10'h008, acc);
    repeat (T_CP - 1) @(negedge clk);
    send(1'b0, 2'd3, 13'h00AA, 10'h010, acc);
    repeat (T_CP) @(negedge clk);
    send(1'b1, 2'd3, 13'h00AA, 10'h018, acc);
    repeat (30) @(negedge clk);
    push(K_ACT, 3, 'h0AA, -1, "R3");
    push(K_RD, 3, 'h000, T_RCD, "R4");
    push(K_RD, 3, 'h008, T_CCD, "R4");
    push(K_RD, 3, 'h010, T_CP, "R6 same-cycle hit");
    push(K_PRE, 3, 0, T_CP, "R6 idle close");
    push(K_ACT, 3, 'h0AA, T_RP, "R3");
    push(K_WR, 3, 'h018, T_RCD, "R4");
    push(K_PRE, 3, 0, T_CP, "R6");
    compare_log("boundary");

    check(cs_bad == 0, "R2 cs_n held low", cs_bad, 0);
    report();
    $finish;
  end
endmodule